// File: doc/BRIEF.md
# Inclusive Directory Tag Array with Targeted Invalidation

This block holds the tags of a shared outer cache level that is strictly inclusive of the private caches of four cores. Because every line held by any core also has a tag here, the tag array doubles as a coherence filter. Each entry keeps one presence bit per core, marking the cores that may hold a copy. A presence bit may stay set after a core has dropped the line without telling anyone, so a set bit means only "possibly present".

A core issues a shared read or an ownership request for a 64-byte line. A shared read records the requester and is granted at once. An ownership request sends invalidations only to the other cores whose presence bits are set. It waits until each of them has acknowledged, and then grants with the requester as the only holder. On a miss, the block picks a way: an empty way if the set has one, otherwise the least recently used way. If the victim is valid, every core flagged in it is invalidated at the victim's line address, and the block waits for their acknowledgements before it installs the new tag. Only one transaction is in flight at a time. A core that gets an invalidation for a line it no longer has simply acknowledges it.

Top module: `snoopf_dir`

## Requirements
- R1: After reset, `req_ready` is 1, `inv_valid` is 0 and `gnt_valid` is 0, and every way of every set is empty.
- R2: A shared request (`req_excl`=0) that hits produces no invalidation. The grant pulse (`gnt_valid`=1, `gnt_hit`=1, `gnt_core` = requester) appears in the second cycle after acceptance. The requester is added to the line's presence bits.
- R3: A request that misses installs the tag with only the requester's presence bit set, and grants with `gnt_hit`=0.
- R4: An ownership request (`req_excl`=1) that hits drives a one-cycle `inv_valid` pulse, in the second cycle after acceptance. Bit i of the pulse stands for core i, and only the other cores flagged in the presence bits are set; the requester's bit is never set. `inv_addr` carries the line address with its low 6 bits zero.
- R5: After an invalidation pulse, the grant comes only in the cycle after the edge at which the last invalidated core's `inv_ack` bit was seen. `inv_ack` bits from cores that were not invalidated have no effect.
- R6: After an ownership grant, the line's presence bits hold only the requester.
- R7: An ownership request that hits a line flagged for no other core is granted without an invalidation pulse, with the same timing as R2.
- R8: On a miss, an empty way of the set is used if there is one. Otherwise the way used least recently by a grant in that set is replaced.
- R9: Replacing a valid line first sends an invalidation pulse to every core flagged in the victim, the requester included, at the victim's line address. The grant then waits for those acknowledgements as in R5.
- R10: Byte addresses within one 64-byte line map to the same entry. The set index is `req_addr[9:6]` and the tag is `req_addr[31:10]`.
- R11: `req_ready` is 0 from the cycle after acceptance until the grant cycle, in which it is 1 again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request accepted when both are high |
| req_core | input | 2 | Requesting core |
| req_excl | input | 1 | 1 = ownership request, 0 = shared read |
| req_addr | input | 32 | Byte address of the requested line |
| inv_valid | output | 4 | One-cycle invalidation pulse, one bit per core |
| inv_addr | output | 32 | Line address being invalidated |
| inv_ack | input | 4 | Invalidation acknowledgement, one bit per core |
| gnt_valid | output | 1 | One-cycle grant pulse |
| gnt_core | output | 2 | Core receiving the grant |
| gnt_hit | output | 1 | 1 if the tag was already present |

## Verification
The assertions check on every cycle that there is only one request in flight, that an invalidation is a single-cycle pulse that never includes the owner-to-be, that no grant comes while an acknowledgement is still owed, that pending acknowledgements only ever shrink, that at most one way matches a tag, and that a granted way becomes the most recent in its set. Which cores are targeted, which way is the victim and its address, and how the presence bits build up and collapse over a sequence of requests can only be shown by the bench's scenarios. The bench compares them against a recency-list model, using directed sequences and a pseudo-random stream over two sets.

// File: rtl/snoopf_pkg.sv
package snoopf_pkg;
    localparam int unsigned NCORE      = 4;
    localparam int unsigned NWAY       = 4;
    localparam int unsigned NSET       = 16;
    localparam int unsigned ADDR_W     = 32;
    localparam int unsigned LINE_BYTES = 64;

    localparam int unsigned OFF_W  = $clog2(LINE_BYTES);
    localparam int unsigned IDX_W  = $clog2(NSET);
    localparam int unsigned TAG_W  = ADDR_W - OFF_W - IDX_W;
    localparam int unsigned CORE_W = $clog2(NCORE);
    localparam int unsigned WAY_W  = $clog2(NWAY);

    typedef logic [NCORE-1:0]  cmask_t;
    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [WAY_W-1:0]  way_t;
    typedef logic [CORE_W-1:0] core_t;
    typedef logic [ADDR_W-1:0] addr_t;

    typedef struct packed {
        logic   vld;
        tag_t   tag;
        cmask_t pres;
    } entry_t;

    typedef struct packed {
        core_t core;
        logic  excl;
        tag_t  tag;
        idx_t  idx;
    } txn_t;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_LOOK = 2'd1,
        S_WAIT = 2'd2
    } state_t;

    function automatic cmask_t core_bit(core_t c);
        return cmask_t'(1) << c;
    endfunction

    function automatic addr_t line_addr(tag_t t, idx_t i);
        return {t, i, {OFF_W{1'b0}}};
    endfunction
endpackage

// File: rtl/snoopf_match.sv
module snoopf_match
    import snoopf_pkg::*;
(
    input  entry_t ent [NWAY],
    input  way_t   age [NWAY],
    input  tag_t   tag,
    output logic   hit,
    output way_t   hit_way,
    output way_t   vict_way,
    output logic [NWAY-1:0] hit_vec
);
    logic [NWAY-1:0] empty_vec;

    for (genvar w = 0; w < NWAY; w++) begin : g_way
        assign hit_vec[w]   = ent[w].vld && (ent[w].tag == tag);
        assign empty_vec[w] = !ent[w].vld;
    end

    assign hit = |hit_vec;

    always_comb begin
        hit_way = '0;
        for (int w = 0; w < NWAY; w++) begin
            if (hit_vec[w]) hit_way = way_t'(w);
        end
    end

    // Lowest empty way first; with a full set, the oldest way.
    always_comb begin
        vict_way = '0;
        for (int w = 0; w < NWAY; w++) begin
            if (age[w] == way_t'(NWAY - 1)) vict_way = way_t'(w);
        end
        for (int w = NWAY - 1; w >= 0; w--) begin
            if (empty_vec[w]) vict_way = way_t'(w);
        end
    end
endmodule

// File: rtl/snoopf_ack.sv
module snoopf_ack
    import snoopf_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   load,
    input  cmask_t load_mask,
    input  cmask_t ack,
    output cmask_t pending,
    output logic   done
);
    always_ff @(posedge clk) begin
        if (rst)       pending <= '0;
        else if (load) pending <= load_mask;
        else           pending <= pending & ~ack;
    end

    assign done = (pending & ~ack) == '0;

    // R5: outstanding acknowledgements never gain a core except on a new load
    p_pend_no_grow_r5: assert property (@(posedge clk) disable iff (rst)
        !load |=> ((pending & ~$past(pending)) == '0));
endmodule

// File: rtl/snoopf_dir.sv
module snoopf_dir
    import snoopf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [CORE_W-1:0] req_core,
    input  logic              req_excl,
    input  logic [ADDR_W-1:0] req_addr,
    output logic [NCORE-1:0]  inv_valid,
    output logic [ADDR_W-1:0] inv_addr,
    input  logic [NCORE-1:0]  inv_ack,
    output logic              gnt_valid,
    output logic [CORE_W-1:0] gnt_core,
    output logic              gnt_hit
);
    state_t st;
    txn_t   q;
    logic   q_hit;
    way_t   q_way;

    entry_t tbl [NSET][NWAY];
    way_t   age [NSET][NWAY];

    entry_t row     [NWAY];
    way_t   row_age [NWAY];

    logic            m_hit;
    way_t            m_hit_way, m_vict;
    logic [NWAY-1:0] m_hit_vec;

    cmask_t cb, tgt, pend;
    addr_t  look_addr;
    entry_t vict;
    logic   c_hit, do_commit, load, ack_done;
    way_t   c_way;

    logic unused_off;
    assign unused_off = ^req_addr[OFF_W-1:0];

    assign req_ready = (st == S_IDLE);

    always_comb begin
        for (int w = 0; w < NWAY; w++) begin
            row[w]     = tbl[q.idx][w];
            row_age[w] = age[q.idx][w];
        end
    end

    snoopf_match u_match (
        .ent      (row),
        .age      (row_age),
        .tag      (q.tag),
        .hit      (m_hit),
        .hit_way  (m_hit_way),
        .vict_way (m_vict),
        .hit_vec  (m_hit_vec)
    );

    // Targets and address of the invalidation decided in the lookup cycle
    always_comb begin
        cb   = core_bit(q.core);
        vict = row[m_vict];
        if (m_hit) begin
            tgt       = q.excl ? (row[m_hit_way].pres & ~cb) : '0;
            look_addr = line_addr(q.tag, q.idx);
        end else begin
            tgt       = vict.vld ? vict.pres : '0;
            look_addr = line_addr(vict.tag, q.idx);
        end
    end

    assign c_hit     = (st == S_LOOK) ? m_hit : q_hit;
    assign c_way     = (st == S_LOOK) ? (m_hit ? m_hit_way : m_vict) : q_way;
    assign load      = (st == S_LOOK) && (tgt != '0);
    assign do_commit = ((st == S_LOOK) && (tgt == '0)) || ((st == S_WAIT) && ack_done);

    snoopf_ack u_ack (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .load_mask (tgt),
        .ack       (inv_ack),
        .pending   (pend),
        .done      (ack_done)
    );

    // Control and output pulses
    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= S_IDLE;
            q         <= '0;
            q_hit     <= 1'b0;
            q_way     <= '0;
            inv_valid <= '0;
            inv_addr  <= '0;
            gnt_valid <= 1'b0;
            gnt_core  <= '0;
            gnt_hit   <= 1'b0;
        end else begin
            inv_valid <= '0;
            gnt_valid <= 1'b0;
            unique case (st)
                S_IDLE: begin
                    if (req_valid) begin
                        q.core <= req_core;
                        q.excl <= req_excl;
                        q.tag  <= req_addr[ADDR_W-1 -: TAG_W];
                        q.idx  <= req_addr[OFF_W +: IDX_W];
                        st     <= S_LOOK;
                    end
                end
                S_LOOK: begin
                    q_hit <= m_hit;
                    q_way <= m_hit ? m_hit_way : m_vict;
                    if (load) begin
                        inv_valid <= tgt;
                        inv_addr  <= look_addr;
                        st        <= S_WAIT;
                    end else begin
                        st <= S_IDLE;
                    end
                end
                S_WAIT: begin
                    if (ack_done) st <= S_IDLE;
                end
                default: st <= S_IDLE;
            endcase
            if (do_commit) begin
                gnt_valid <= 1'b1;
                gnt_core  <= q.core;
                gnt_hit   <= c_hit;
            end
        end
    end

    // Tag, presence and recency storage
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < NSET; s++) begin
                for (int w = 0; w < NWAY; w++) begin
                    tbl[s][w] <= '0;
                    age[s][w] <= way_t'(w);
                end
            end
        end else if (do_commit) begin
            for (int w = 0; w < NWAY; w++) begin
                if (way_t'(w) == c_way)
                    age[q.idx][w] <= '0;
                else if (age[q.idx][w] < age[q.idx][c_way])
                    age[q.idx][w] <= age[q.idx][w] + way_t'(1);
            end
            tbl[q.idx][c_way].vld  <= 1'b1;
            tbl[q.idx][c_way].tag  <= q.tag;
            tbl[q.idx][c_way].pres <= (c_hit && !q.excl) ? (row[c_way].pres | cb) : cb;
        end
    end

    // R11: one transaction at a time
    p_one_txn_r11: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    // R4: invalidation is a single-cycle pulse
    p_inv_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        (inv_valid != '0) |=> (inv_valid == '0));

    // R4: an ownership hit never invalidates the requester itself
    p_excl_skips_req_r4: assert property (@(posedge clk) disable iff (rst)
        (st == S_LOOK && m_hit && q.excl) |=> !inv_valid[q.core]);

    // R5: no grant while an acknowledgement is still owed
    p_no_early_gnt_r5: assert property (@(posedge clk) disable iff (rst)
        (st == S_WAIT && !ack_done) |=> !gnt_valid);

    // R5: grant and invalidation never share a cycle
    p_gnt_inv_apart_r5: assert property (@(posedge clk) disable iff (rst)
        !(gnt_valid && (inv_valid != '0)));

    // R10: a tag matches at most one way of its set
    p_unique_hit_r10: assert property (@(posedge clk) disable iff (rst)
        (st == S_LOOK) |-> $onehot0(m_hit_vec));

    // R8: the granted way becomes the most recent in its set
    p_lru_touch_r8: assert property (@(posedge clk) disable iff (rst)
        do_commit |=> (age[q.idx][$past(c_way)] == '0));
endmodule

// File: tb/snoopf_dir_tb.sv
module snoopf_dir_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic        req_ready;
    logic [1:0]  req_core;
    logic        req_excl;
    logic [31:0] req_addr;
    logic [3:0]  inv_valid;
    logic [31:0] inv_addr;
    logic [3:0]  inv_ack;
    logic        gnt_valid;
    logic [1:0]  gnt_core;
    logic        gnt_hit;

    int errors = 0;
    int checks = 0;
    bit done_flag = 0;

    // Reference model: per set, a recency list (slot 0 = most recent)
    int m_tag  [16][4];
    int m_pres [16][4];
    int m_cnt  [16];

    always #2 clk = ~clk;

    snoopf_dir u_dut (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_core  (req_core),
        .req_excl  (req_excl),
        .req_addr  (req_addr),
        .inv_valid (inv_valid),
        .inv_addr  (inv_addr),
        .inv_ack   (inv_ack),
        .gnt_valid (gnt_valid),
        .gnt_core  (gnt_core),
        .gnt_hit   (gnt_hit)
    );

    task automatic check(input bit ok, input string lbl, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", lbl, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // One full transaction, compared with the model in every cycle
    task automatic do_req(input int c, input logic [31:0] a, input bit ex, input int dly,
                          input string lbl);
        int idx = int'(a[9:6]);
        int tg  = int'(a[31:10]);
        int pos = -1;
        int tgt = 0;
        int npres;
        bit hit;
        logic [31:0] iaddr;
        string il;
        for (int i = 0; i < m_cnt[idx]; i++) if (m_tag[idx][i] == tg) pos = i;
        hit = (pos >= 0);
        if (hit) begin
            tgt   = ex ? (m_pres[idx][pos] & ~(1 << c)) : 0;
            iaddr = {a[31:6], 6'b0};
            npres = ex ? (1 << c) : (m_pres[idx][pos] | (1 << c));
            il    = "R4";
        end else begin
            npres = 1 << c;
            il    = "R9";
            if (m_cnt[idx] == 4) begin
                tgt   = m_pres[idx][3];
                iaddr = {m_tag[idx][3][21:0], a[9:6], 6'b0};
            end
        end

        check(req_ready == 1'b1, {lbl, "/R11 ready idle"}, req_ready, 1);
        req_valid = 1'b1; req_core = 2'(c); req_excl = ex; req_addr = a;
        tick();
        req_valid = 1'b0;
        check(req_ready == 1'b0, {lbl, "/R11 busy"}, req_ready, 0);
        check(gnt_valid == 1'b0 && inv_valid == 4'd0, {lbl, "/R2 quiet lookup"},
              {gnt_valid, inv_valid}, 0);
        tick();
        if (tgt != 0) begin
            check(inv_valid == 4'(tgt), {lbl, "/", il, " inv targets"}, inv_valid, tgt);
            check(inv_addr == iaddr, {lbl, "/", il, " inv addr"}, inv_addr, iaddr);
            check(gnt_valid == 1'b0, {lbl, "/R5 no grant with inv"}, gnt_valid, 0);
            if ((~tgt & 15) != 0) begin
                inv_ack = 4'(~tgt);
                tick();
                inv_ack = 4'd0;
                check(gnt_valid == 1'b0, {lbl, "/R5 stray ack ignored"}, gnt_valid, 0);
                check(inv_valid == 4'd0, {lbl, "/R4 single pulse"}, inv_valid, 0);
            end
            for (int k = 0; k < 4; k++) begin
                if (tgt[k]) begin
                    bit last;
                    for (int d = 0; d < dly; d++) begin
                        tick();
                        check(gnt_valid == 1'b0, {lbl, "/R5 waiting"}, gnt_valid, 0);
                        check(req_ready == 1'b0, {lbl, "/R11 busy wait"}, req_ready, 0);
                    end
                    inv_ack = 4'(1 << k);
                    tick();
                    inv_ack = 4'd0;
                    last = ((tgt >> (k + 1)) == 0);
                    check(gnt_valid == last, {lbl, "/R5 grant after last ack"}, gnt_valid, int'(last));
                end
            end
        end else begin
            check(inv_valid == 4'd0, {lbl, "/R7 no inv"}, inv_valid, 0);
            check(gnt_valid == 1'b1, {lbl, "/R2 grant timing"}, gnt_valid, 1);
        end
        check(gnt_hit == hit, {lbl, hit ? "/R2 hit flag" : "/R3 miss flag"}, gnt_hit, int'(hit));
        check(gnt_core == 2'(c), {lbl, "/R2 grant core"}, gnt_core, c);

        // Model update: move or insert at the most recent slot
        if (hit) begin
            for (int i = pos; i > 0; i--) begin
                m_tag[idx][i] = m_tag[idx][i-1]; m_pres[idx][i] = m_pres[idx][i-1];
            end
        end else begin
            if (m_cnt[idx] < 4) m_cnt[idx]++;
            for (int i = m_cnt[idx] - 1; i > 0; i--) begin
                m_tag[idx][i] = m_tag[idx][i-1]; m_pres[idx][i] = m_pres[idx][i-1];
            end
        end
        m_tag[idx][0]  = tg;
        m_pres[idx][0] = npres;
    endtask

    function automatic logic [31:0] mk(input int tg, input int idx, input int off);
        return {22'(tg), 4'(idx), 6'(off)};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done_flag) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int seed = 32'h1234_5677;
        for (int s = 0; s < 16; s++) m_cnt[s] = 0;
        rst = 1'b1; req_valid = 1'b0; req_core = '0; req_excl = 1'b0;
        req_addr = '0; inv_ack = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check(req_ready == 1'b1, "R1 ready", req_ready, 1);
        check(inv_valid == 4'd0, "R1 inv", inv_valid, 0);
        check(gnt_valid == 1'b0, "R1 gnt", gnt_valid, 0);

        // R3 miss fill, then R10 other byte of same line hits, R2 shared hits
        do_req(0, mk(5, 2, 0),  0, 0, "R3");
        do_req(1, mk(5, 2, 37), 0, 0, "R10");
        do_req(2, mk(5, 2, 63), 0, 1, "R2");
        // R4/R5: ownership by core1 invalidates 0 and 2 only
        do_req(1, mk(5, 2, 8),  1, 2, "R4");
        // R6: presence collapsed to core1 alone, core3 ownership hits only core1
        do_req(3, mk(5, 2, 0),  1, 1, "R6");
        // R7: sole holder asks again
        do_req(3, mk(5, 2, 4),  1, 0, "R7");
        do_req(0, mk(5, 2, 0),  0, 0, "R2");
        do_req(0, mk(5, 2, 0),  1, 0, "R4");

        // R8/R9: fill set 9, refresh one line, then force evictions
        do_req(0, mk(1, 9, 0), 0, 0, "R8");
        do_req(1, mk(2, 9, 0), 0, 0, "R8");
        do_req(2, mk(3, 9, 0), 0, 0, "R8");
        do_req(3, mk(4, 9, 0), 0, 0, "R8");
        do_req(2, mk(2, 9, 0), 0, 0, "R8");
        do_req(3, mk(1, 9, 0), 0, 0, "R8");
        do_req(1, mk(6, 9, 0), 0, 1, "R9");
        do_req(0, mk(7, 9, 0), 1, 0, "R9");
        do_req(2, mk(3, 9, 0), 0, 2, "R9");

        // Pseudo-random stream over two sets
        for (int n = 0; n < 300; n++) begin
            int r;
            seed = seed ^ (seed << 13);
            seed = seed ^ (seed >>> 17);
            seed = seed ^ (seed << 5);
            r = seed & 32'h7fff_ffff;
            do_req(r % 4, mk((r >> 4) % 6, ((r >> 8) & 1) ? 3 : 12, (r >> 9) & 63),
                   bit'((r >> 15) & 1), (r >> 16) % 3, "RND");
        end

        done_flag = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule